// File: doc/BRIEF.md
# Cascadable Synchronous Counter with Offset Sequences

This block provides a 4-bit synchronous up-counter slice with synchronous clear, synchronous parallel load, two count enables and a carry output. The carry is qualified by the second enable, so that slices can be chained into a wider counter. A cascade of two slices forms an 8-bit counter that is driven directly from the block's ports.

The same slice is reused for two self-running offset sequences. The first offset counter feeds its own carry back into its load input, with the data inputs tied to a preset value, so it restarts at the preset after reaching all ones. The second offset counter decodes a terminal value and feeds it back into its synchronous clear, so it returns to zero on the edge after it reaches that value.

All state changes happen on the rising clock edge. The ports carry no asynchronous paths into the state.

Top module: `ofs_counter_top`

## Requirements
- R1: While `rst` is high at a rising edge, every count output becomes 0 on that edge, and every carry output is 0 after the edge.
- R2: A slice adds 1 to its value (modulo 16) on an edge only when both count enables (`en_p` and the slice's T enable) are high. Otherwise it holds its value.
- R3: A slice's carry is 1 exactly when its value is 4'b1111 and its T enable is 1. When T is 0, the carry is 0 even at 4'b1111.
- R4: With `clr_n` low at an edge, the 8-bit count becomes 0 on that edge. This overrides load and count.
- R5: With `clr_n` high and `ld_n` low at an edge, the 8-bit count takes the value of `din` on that edge. This overrides counting, and the new value does not appear at `cnt_q` before that edge.
- R6: In the cascade, the low slice's carry is the high slice's T enable. The high nibble therefore increments on the edge where the low nibble wraps from 4'hF to 4'h0. The 8-bit count wraps from 8'hFF to 8'h00, and `cnt_rco` is 1 when the count is 8'hFF and `en_t` is 1.
- R7: The starting-offset counter, while `ofs_en` is high, moves from 4'hF to the preset `START_VAL` (default 4'h6) and otherwise adds 1. `start_rco` is 1 when it is at 4'hF and `ofs_en` is 1.
- R8: The ending-offset counter, while `ofs_en` is high, runs from 0 up to `END_VAL` (default 4'hD). It holds `END_VAL` for exactly one clock period and returns to 0 on the next edge.
- R9: With `ofs_en` low, both offset counters hold their values. The one exception is that the ending-offset counter at `END_VAL` still clears to 0, because clear does not depend on the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Synchronous clear of the cascade, active low |
| ld_n | input | 1 | Synchronous parallel load of the cascade, active low |
| en_p | input | 1 | Count enable shared by all cascade slices |
| en_t | input | 1 | Count enable of the low slice; also qualifies the carries |
| din | input | 8 | Parallel load value for the cascade |
| ofs_en | input | 1 | Count enable for both offset counters |
| cnt_q | output | 8 | Cascaded counter value |
| cnt_rco | output | 1 | Carry out of the high slice |
| start_q | output | 4 | Starting-offset counter value |
| start_rco | output | 1 | Carry of the starting-offset counter |
| end_q | output | 4 | Ending-offset counter value |
| end_rco | output | 1 | Carry of the ending-offset counter |

## Verification
A bad internal state shows up at the ports on the very edge where it is produced. All three counter values are direct register outputs, and every carry is decoded from those registers and the current enable, so a wrong state appears one quarter period after the edge. A broken carry chain shows up first as a high nibble that fails to step when the low nibble wraps, or that steps while it is not wrapping. A broken feedback path in an offset counter shows up within one sequence period, as a missing return to the preset or to zero.

// File: rtl/ofs_cnt_pkg.sv
package ofs_cnt_pkg;

  // Selects how an offset unit closes its sequence
  typedef enum logic {
    OFS_RELOAD_AT_TOP = 1'b0,  // carry drives load with a preset
    OFS_CLEAR_AT_TERM = 1'b1   // terminal decode drives clear
  } ofs_mode_e;

endpackage

// File: rtl/cnt_slice.sv
module cnt_slice #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry
);

  localparam logic [W-1:0] ONE = W'(1);

  // clear beats load, load beats count
  always_ff @(posedge clk) begin
    if (rst)            q <= '0;
    else if (!clr_n)    q <= '0;
    else if (!ld_n)     q <= din;
    else if (en_p && en_t) q <= q + ONE;
  end

  assign carry = (&q) & en_t;

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (q == '0));

  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !ld_n) |=> (q == $past(din)));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (clr_n && ld_n && !(en_p && en_t)) |=> $stable(q));

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_n && ld_n && en_p && carry) |=> (q == '0));

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
  parameter int W = 4,
  parameter int N = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_n,
  input  logic           ld_n,
  input  logic           en_p,
  input  logic           en_t,
  input  logic [W*N-1:0] din,
  output logic [W*N-1:0] q,
  output logic           carry
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [N:0] t_link;
  assign t_link[0] = en_t;

  for (genvar i = 0; i < N; i++) begin : g_slice
    cnt_slice #(.W(W)) u_slice (
      .clk   (clk),
      .rst   (rst),
      .clr_n (clr_n),
      .ld_n  (ld_n),
      .en_p  (en_p),
      .en_t  (t_link[i]),
      .din   (din[i*W +: W]),
      .q     (q[i*W +: W]),
      .carry (t_link[i+1])
    );

    if (i > 0) begin : g_link_chk
      p_cascade_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_n && ld_n && en_p && t_link[i]) |=>
          (q[i*W +: W] == $past(q[i*W +: W]) + ONE));
      p_no_step_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_n && ld_n && !t_link[i]) |=> $stable(q[i*W +: W]));
    end
  end

  assign carry = t_link[N];

endmodule

// File: rtl/ofs_unit.sv
module ofs_unit
  import ofs_cnt_pkg::*;
#(
  parameter int        W      = 4,
  parameter ofs_mode_e MODE   = OFS_RELOAD_AT_TOP,
  parameter int        MARKER = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] q,
  output logic         carry
);

  localparam logic [W-1:0] MARK = W'(MARKER);

  logic         fb_clr_n;
  logic         fb_ld_n;
  logic [W-1:0] fb_din;

  if (MODE == OFS_RELOAD_AT_TOP) begin : g_reload
    assign fb_clr_n = 1'b1;
    assign fb_ld_n  = ~carry;
    assign fb_din   = MARK;

    p_reload_r7: assert property (@(posedge clk) disable iff (rst)
      carry |=> (q == MARK));
  end else begin : g_term_clear
    assign fb_clr_n = ~(q == MARK);
    assign fb_ld_n  = 1'b1;
    assign fb_din   = '0;

    p_term_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (q == MARK) |=> (q == '0));
  end

  cnt_slice #(.W(W)) u_core (
    .clk   (clk),
    .rst   (rst),
    .clr_n (fb_clr_n),
    .ld_n  (fb_ld_n),
    .en_p  (en),
    .en_t  (en),
    .din   (fb_din),
    .q     (q),
    .carry (carry)
  );

endmodule

// File: rtl/ofs_counter_top.sv
module ofs_counter_top
  import ofs_cnt_pkg::*;
#(
  parameter int SLICE_W   = 4,
  parameter int N_SLICES  = 2,
  parameter int START_VAL = 6,
  parameter int END_VAL   = 13
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr_n,
  input  logic                          ld_n,
  input  logic                          en_p,
  input  logic                          en_t,
  input  logic [SLICE_W*N_SLICES-1:0]   din,
  input  logic                          ofs_en,
  output logic [SLICE_W*N_SLICES-1:0]   cnt_q,
  output logic                          cnt_rco,
  output logic [SLICE_W-1:0]            start_q,
  output logic                          start_rco,
  output logic [SLICE_W-1:0]            end_q,
  output logic                          end_rco
);

  localparam int TOT_W = SLICE_W * N_SLICES;

  cnt_chain #(.W(SLICE_W), .N(N_SLICES)) u_chain (
    .clk   (clk),
    .rst   (rst),
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .din   (din),
    .q     (cnt_q),
    .carry (cnt_rco)
  );

  ofs_unit #(.W(SLICE_W), .MODE(OFS_RELOAD_AT_TOP), .MARKER(START_VAL)) u_start (
    .clk   (clk),
    .rst   (rst),
    .en    (ofs_en),
    .q     (start_q),
    .carry (start_rco)
  );

  ofs_unit #(.W(SLICE_W), .MODE(OFS_CLEAR_AT_TERM), .MARKER(END_VAL)) u_end (
    .clk   (clk),
    .rst   (rst),
    .en    (ofs_en),
    .q     (end_q),
    .carry (end_rco)
  );

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (cnt_q == '0 && start_q == '0 && end_q == '0));

  p_full_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_n && ld_n && en_p && cnt_rco) |=> (cnt_q == TOT_W'(0)));

  p_ofs_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !ofs_en |=> $stable(start_q));

endmodule

// File: tb/ofs_counter_top_test.sv
module ofs_counter_top_test;

  localparam int CLK_P = 10;
  localparam logic [3:0] START = 4'd6;
  localparam logic [3:0] TERM  = 4'd13;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr_n = 1'b1, ld_n = 1'b1, en_p = 1'b0, en_t = 1'b0, ofs_en = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] cnt_q;
  logic       cnt_rco, start_rco, end_rco;
  logic [3:0] start_q, end_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [7:0] cm = '0;
  logic [3:0] sm = '0, em = '0;

  // scoreboard
  logic [18:0] exp_q[$];
  string       tag_q[$];

  ofs_counter_top uut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t),
    .din(din), .ofs_en(ofs_en), .cnt_q(cnt_q), .cnt_rco(cnt_rco),
    .start_q(start_q), .start_rco(start_rco), .end_q(end_q), .end_rco(end_rco)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic step(input logic r, input logic c, input logic l, input logic p,
                      input logic t, input logic [7:0] d, input logic oe,
                      input string tag);
    logic [3:0] lo, hi, nlo, nhi, nsm, nem;
    logic [7:0] ncm;
    logic       lc;
    @(negedge clk);
    rst = r; clr_n = c; ld_n = l; en_p = p; en_t = t; din = d; ofs_en = oe;
    lo = cm[3:0]; hi = cm[7:4];
    if (r || !c)     ncm = 8'h00;
    else if (!l)     ncm = d;
    else begin
      lc  = (lo == 4'hF) && t;
      nlo = (p && t)  ? lo + 4'd1 : lo;
      nhi = (p && lc) ? hi + 4'd1 : hi;
      ncm = {nhi, nlo};
    end
    if (r)                       nsm = 4'd0;
    else if (oe && sm == 4'hF)   nsm = START;
    else if (oe)                 nsm = sm + 4'd1;
    else                         nsm = sm;
    if (r)                       nem = 4'd0;
    else if (em == TERM)         nem = 4'd0;
    else if (oe)                 nem = em + 4'd1;
    else                         nem = em;
    if (!l && !r && c) begin
      #1;
      checks++;
      if (cnt_q !== cm) begin
        errors++;
        $display("FAIL R5 load visible before edge: cnt_q=%h expected %h", cnt_q, cm);
      end
    end
    @(posedge clk);
    #1;
    cm = ncm; sm = nsm; em = nem;
    exp_q.push_back({cm, (cm == 8'hFF) && t, sm, (sm == 4'hF) && oe, em, (em == 4'hF) && oe});
    tag_q.push_back(tag);
  endtask

  // monitor: samples a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (exp_q.size() > 0) begin
        logic [18:0] e;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        checks++;
        if ({cnt_q, cnt_rco} !== e[18:10]) begin
          errors++;
          $display("FAIL %s cascade: q=%h rco=%b expected q=%h rco=%b",
                   tg, cnt_q, cnt_rco, e[18:11], e[10]);
        end
        if ({start_q, start_rco} !== e[9:5]) begin
          errors++;
          $display("FAIL R7 (%s) start-offset: q=%h rco=%b expected q=%h rco=%b",
                   tg, start_q, start_rco, e[9:6], e[5]);
        end
        if ({end_q, end_rco} !== e[4:0]) begin
          errors++;
          $display("FAIL R8 (%s) end-offset: q=%h rco=%b expected q=%h rco=%b",
                   tg, end_q, end_rco, e[4:1], e[0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(1, 1, 1, 1, 1, 8'h00, 1, "R1");
    step(1, 1, 1, 1, 1, 8'h00, 1, "R1");
    // R6 R7 R8: free run past the 8-bit wrap and several offset wraps
    for (int i = 0; i < 300; i++) step(0, 1, 1, 1, 1, 8'h00, 1, "R6");
    // R2: en_p low holds
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 1, 8'h00, 1, "R2");
    // R2: en_t low holds
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 0, 8'h00, 1, "R2");
    // R3: low nibble at 1111 with T low, carry must stay low
    step(0, 1, 0, 1, 0, 8'h3F, 1, "R5");
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 0, 8'h00, 1, "R3");
    // R3: T high, P low: carry high, no count
    step(0, 1, 1, 0, 1, 8'h00, 1, "R3");
    step(0, 1, 1, 1, 1, 8'h00, 1, "R3");
    // R5: load near top, then count through full wrap
    step(0, 1, 0, 1, 1, 8'hFD, 1, "R5");
    for (int i = 0; i < 5; i++) step(0, 1, 1, 1, 1, 8'h00, 1, "R6");
    // R4: clear beats load and count
    step(0, 1, 0, 1, 1, 8'hA7, 1, "R5");
    step(0, 0, 0, 1, 1, 8'h55, 1, "R4");
    step(0, 1, 1, 1, 1, 8'h00, 1, "R4");
    // R9: offset counters hold with ofs_en low
    while (em == TERM) step(0, 1, 1, 1, 1, 8'h00, 1, "R9");
    for (int i = 0; i < 4; i++) step(0, 1, 1, 1, 1, 8'h00, 0, "R9");
    // R9: ending counter at terminal clears even with ofs_en low
    while (em != TERM) step(0, 1, 1, 1, 1, 8'h00, 1, "R8");
    step(0, 1, 1, 1, 1, 8'h00, 0, "R9");
    step(0, 1, 1, 1, 1, 8'h00, 0, "R9");
    // more offset wraps
    for (int i = 0; i < 40; i++) step(0, 1, 1, 1, 1, 8'h00, 1, "R7");
    // R1: reset in mid-run
    step(1, 1, 1, 1, 1, 8'h00, 1, "R1");
    step(0, 1, 1, 1, 1, 8'h00, 1, "R1");
    repeat (3) @(posedge clk);
    #5;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule